// File: doc/BRIEF.md
# Serial Byte Transmitter with Break Override and Receive-Error Interlock

This block serialises bytes from a one-entry holding register onto a single transmit line. In asynchronous mode it sends a framed character: start bit, data bits least-significant first, an optional even-parity bit, and a stop bit. In clocked synchronous mode it sends only the data bits and drives a serial clock alongside them. Bit timing comes from an external one-cycle `bitTick` strobe, because the baud-rate source sits outside the block.

The host loads a byte by pulsing `wrStrobe`. It can tell that the holding register has room again from `dataEmpty`. When `txEnable` is low the transmitter returns to idle at once. The line then follows a port-level override, `portLevel` gated by `portSelect`, which the host uses to hold the line at mark or to drive a break. In synchronous mode no new frame starts while any receive error flag is raised.

Top module: `serTxTop`

## Requirements
- R1: After reset, `dataEmpty` is 1, `txd` is 1 and `sclk` is 1.
- R2: While enabled, a `wrStrobe` stores `wrData` and clears `dataEmpty` on the next edge. `dataEmpty` goes back to 1 on the `bitTick` edge that moves the held byte into the shift register.
- R3: An asynchronous frame holds each bit for one `bitTick` period, in this order: 0 (start), data bits LSB first, then the even-parity bit (the XOR of the data bits) only when `parityEn` is 1, then 1 (stop). After the stop bit, `txd` returns to 1.
- R4: In synchronous mode (`syncMode` = 1) each data bit, LSB first, takes two ticks. `sclk` falls together with each new bit on the first tick and rises on the second tick. `sclk` stays at 1 whenever no frame is in progress.
- R5: In synchronous mode, while any of `errOverrun`, `errFraming` or `errParity` is 1, no frame starts. `dataEmpty` stays 0 and `txd` and `sclk` stay at 1.
- R6: Once all error flags are 0, a pending synchronous frame starts on the next `bitTick`.
- R7: In asynchronous mode the receive error flags have no effect on starting a frame.
- R8: Lowering `txEnable` abandons any frame at once. By the next edge `sclk` is 1 and `dataEmpty` is 1, and after re-enabling the block is idle.
- R9: While `txEnable` is 0, `txd` equals `portLevel` when `portSelect` is 1, and equals 1 when `portSelect` is 0. This takes effect in the same cycle.
- R10: A `wrStrobe` while `txEnable` is 0 is ignored: `dataEmpty` stays 1.
- R11: If a byte is waiting when a frame ends, the next frame starts on the same tick that ends the current one, with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle bit-period strobe |
| txEnable | input | 1 | Transmitter enable; low resets the transmitter and hands the line to the override |
| syncMode | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| parityEn | input | 1 | Adds the even-parity bit in asynchronous frames |
| wrStrobe | input | 1 | Write pulse for the holding register |
| wrData | input | DATA_W | Byte to transmit |
| errOverrun | input | 1 | Receive overrun flag |
| errFraming | input | 1 | Receive framing-error flag |
| errParity | input | 1 | Receive parity-error flag |
| portLevel | input | 1 | Override line level |
| portSelect | input | 1 | Override drives the line when 1 |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Serial clock in synchronous mode |
| dataEmpty | output | 1 | Holding register has room |

## Verification
The bench builds the block with `DATA_W` = 8. That gives 11-bit asynchronous frames when parity is on and 10-bit frames when it is off, so the bit counter reaches both of its terminal values. The eight-bit synchronous shift also runs through every clock phase of the two-tick bit.

Random bytes in random modes, with random error flags in asynchronous mode, are checked bit by bit against a model of the frame. Directed cases cover:
- the interlock held on and then released;
- a disable in the middle of a frame;
- break and mark through the override;
- writes while disabled;
- back-to-back frames.

// File: rtl/serTxPkg.sv
package serTxPkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} txState_t;

  typedef struct packed {
    logic load;       // move holding register into shift register
    logic shift;      // advance to the next serial bit
    logic syncFrame;  // frame shape for load
    logic parityOn;   // add parity bit on load
    logic clear;      // transmitter disabled
  } txStrobe_t;
endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import serTxPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_W = DATA_W + 3,
  localparam int CNT_W = $clog2(FRAME_W)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       txEnable,
  input  logic       syncMode,
  input  logic       parityEn,
  input  logic       anyErr,
  input  logic       dataEmpty,
  output txStrobe_t  strobe,
  output logic       busy,
  output logic       sclk
);
  localparam logic [CNT_W-1:0] LAST_PAR   = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_NOPAR = CNT_W'(FRAME_W - 2);
  localparam logic [CNT_W-1:0] LAST_SYNC  = CNT_W'(DATA_W - 1);

  txState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic             phase;
  logic             sclkQ;
  logic             canStart;
  logic             frameEnd;
  logic [CNT_W-1:0] lastAsync;

  assign canStart  = txEnable && !dataEmpty && !(syncMode && anyErr);
  assign lastAsync = parityEn ? LAST_PAR : LAST_NOPAR;

  always_comb begin
    frameEnd = 1'b0;
    strobe   = '0;
    strobe.syncFrame = syncMode;
    strobe.parityOn  = parityEn;
    strobe.clear     = !txEnable;
    if (txEnable && bitTick) begin
      if (state == ST_IDLE) begin
        strobe.load = canStart;
      end else if (syncMode) begin
        if (phase) begin
          if (bitCnt == LAST_SYNC) frameEnd = 1'b1;
          else strobe.shift = 1'b1;
        end
      end else begin
        if (bitCnt == lastAsync) frameEnd = 1'b1;
        else strobe.shift = 1'b1;
      end
      if (frameEnd) strobe.load = canStart;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= 1'b0;
      sclkQ  <= 1'b1;
    end else if (!txEnable) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= 1'b0;
      sclkQ  <= 1'b1;
    end else if (strobe.load) begin
      state  <= ST_SHIFT;
      bitCnt <= '0;
      phase  <= 1'b0;
      sclkQ  <= !syncMode;
    end else if (frameEnd) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= 1'b0;
      sclkQ  <= 1'b1;
    end else if (bitTick && state == ST_SHIFT) begin
      if (syncMode) begin
        if (!phase) begin
          phase <= 1'b1;
          sclkQ <= 1'b1;
        end else begin
          phase  <= 1'b0;
          sclkQ  <= 1'b0;
          bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign busy = (state == ST_SHIFT);
  assign sclk = sclkQ;

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclk) else $error("sclk low while idle"); // R4
  AST_SYNC_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && syncMode && anyErr) |=> !busy) else $error("sync frame started with error"); // R5
  AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (!busy && sclk)) else $error("disable did not reset"); // R8
  AST_ASYNC_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && $stable(syncMode)) |=> sclk) else $error("sclk moved in async mode"); // R4
endmodule

// File: rtl/serTxData.sv
module serTxData
  import serTxPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_W = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              dataEmpty,
  output logic              serBit
);
  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic               emptyQ;
  logic               wrOk;
  logic [FRAME_W-1:0] asyncImage;
  logic [FRAME_W-1:0] syncImage;

  assign wrOk       = wrStrobe && !strobe.clear;
  assign asyncImage = {1'b1, (strobe.parityOn ? ^holdReg : 1'b1), holdReg, 1'b0};
  assign syncImage  = {3'b111, holdReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      emptyQ  <= 1'b1;
    end else begin
      if (wrOk) holdReg <= wrData;
      if (strobe.clear)    emptyQ <= 1'b1;
      else if (wrOk)       emptyQ <= 1'b0;
      else if (strobe.load) emptyQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strobe.clear) begin
      shiftReg <= '1;
    end else if (strobe.load) begin
      shiftReg <= strobe.syncFrame ? syncImage : asyncImage;
    end else if (strobe.shift) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign dataEmpty = emptyQ;
  assign serBit    = shiftReg[0];

  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !dataEmpty) else $error("load with empty holding register"); // R2
  AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !wrStrobe) |=> dataEmpty) else $error("empty not set on load"); // R2
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !strobe.clear) |=> !dataEmpty) else $error("write did not clear empty"); // R2
  AST_DISABLED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> dataEmpty) else $error("empty low after disabled cycle"); // R10
endmodule

// File: rtl/serTxTop.sv
module serTxTop
  import serTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              txEnable,
  input  logic              syncMode,
  input  logic              parityEn,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              errOverrun,
  input  logic              errFraming,
  input  logic              errParity,
  input  logic              portLevel,
  input  logic              portSelect,
  output logic              txd,
  output logic              sclk,
  output logic              dataEmpty
);
  txStrobe_t strobe;
  logic      busy;
  logic      serBit;
  logic      anyErr;

  assign anyErr = errOverrun | errFraming | errParity;

  serTxCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .syncMode(syncMode), .parityEn(parityEn), .anyErr(anyErr),
    .dataEmpty(dataEmpty), .strobe(strobe), .busy(busy), .sclk(sclk)
  );

  serTxData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrStrobe(wrStrobe),
    .wrData(wrData), .dataEmpty(dataEmpty), .serBit(serBit)
  );

  always_comb begin
    if (!txEnable)  txd = portSelect ? portLevel : 1'b1;
    else if (busy)  txd = serBit;
    else            txd = 1'b1;
  end

  AST_OVERRIDE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && !portSelect) |-> txd) else $error("line not at mark while disabled"); // R9
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && !busy) |-> txd) else $error("idle line not at mark"); // R3
endmodule

// File: tb/sim_serTxTop.sv
module sim_serTxTop;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, txEnable = 1'b0, syncMode = 1'b0, parityEn = 1'b0;
  logic wrStrobe = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic errOverrun = 1'b0, errFraming = 1'b0, errParity = 1'b0;
  logic portLevel = 1'b1, portSelect = 1'b0;
  logic txd, sclk, dataEmpty;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serTxTop #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .syncMode(syncMode), .parityEn(parityEn), .wrStrobe(wrStrobe), .wrData(wrData),
    .errOverrun(errOverrun), .errFraming(errFraming), .errParity(errParity),
    .portLevel(portLevel), .portSelect(portSelect),
    .txd(txd), .sclk(sclk), .dataEmpty(dataEmpty)
  );

  function automatic logic evenPar(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
  endtask

  task automatic hostWrite(input logic [DATA_W-1:0] d);
    @(negedge clk) begin wrStrobe = 1'b1; wrData = d; end
    @(negedge clk) wrStrobe = 1'b0;
  endtask

  // Frame already loaded (start bit on the line); checks the rest.
  task automatic asyncRest(input logic [DATA_W-1:0] d, input logic par, input string req);
    for (int i = 0; i < DATA_W; i++) begin
      tick();
      chk({req, " R3 data bit"}, txd, d[i]);
    end
    if (par) begin
      tick();
      chk({req, " R3 parity bit"}, txd, evenPar(d));
    end
    tick();
    chk({req, " R3 stop bit"}, txd, 1);
  endtask

  task automatic asyncFrame(input logic [DATA_W-1:0] d, input logic par, input string req);
    tick();
    chk({req, " R2 empty on load"}, dataEmpty, 1);
    chk({req, " R3 start bit"}, txd, 0);
    asyncRest(d, par, req);
    tick();
    chk({req, " R3 idle after frame"}, txd, 1);
  endtask

  task automatic syncFrame(input logic [DATA_W-1:0] d, input string req);
    for (int i = 0; i < DATA_W; i++) begin
      tick();
      chk({req, " R4 sclk low phase"}, sclk, 0);
      chk({req, " R4 data low phase"}, txd, d[i]);
      tick();
      chk({req, " R4 sclk high phase"}, sclk, 1);
      chk({req, " R4 data high phase"}, txd, d[i]);
    end
    tick();
    chk({req, " R4 sclk idle high"}, sclk, 1);
    chk({req, " R4 line idle"}, txd, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] b;
    logic p;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R1 empty after reset", dataEmpty, 1);
    chk("R1 txd after reset", txd, 1);
    chk("R1 sclk after reset", sclk, 1);
    rstN = 1'b1;
    @(negedge clk) txEnable = 1'b1;

    // Async with parity, and without.
    hostWrite(8'hA5);
    chk("R2 write clears empty", dataEmpty, 0);
    parityEn = 1'b1;
    asyncFrame(8'hA5, 1'b1, "dir1");
    parityEn = 1'b0;
    hostWrite(8'h3C);
    asyncFrame(8'h3C, 1'b0, "dir2");

    // R7: async ignores error flags.
    errFraming = 1'b1; errOverrun = 1'b1;
    hostWrite(8'h81);
    asyncFrame(8'h81, 1'b0, "R7");
    errFraming = 1'b0; errOverrun = 1'b0;

    // R5/R6: sync interlock.
    syncMode = 1'b1;
    errParity = 1'b1;
    hostWrite(8'h96);
    repeat (4) tick();
    chk("R5 held empty", dataEmpty, 0);
    chk("R5 held sclk", sclk, 1);
    chk("R5 held txd", txd, 1);
    errParity = 1'b0;
    @(negedge clk);
    chk("R6 not yet started", sclk, 1);
    syncFrame(8'h96, "R6");
    chk("R6 empty after frame", dataEmpty, 1);

    // R8/R9/R10: disable mid-frame, override.
    hostWrite(8'h5A);
    tick(); tick(); tick();
    portSelect = 1'b1; portLevel = 1'b0;
    @(negedge clk) txEnable = 1'b0;
    #1 chk("R9 break immediate", txd, 0);
    @(negedge clk);
    chk("R8 sclk high after disable", sclk, 1);
    chk("R8 empty after disable", dataEmpty, 1);
    portLevel = 1'b1;
    #1 chk("R9 override mark", txd, 1);
    portSelect = 1'b0; portLevel = 1'b0;
    #1 chk("R9 unselected override", txd, 1);
    hostWrite(8'hFF);
    chk("R10 write ignored", dataEmpty, 1);
    @(negedge clk) txEnable = 1'b1;
    tick();
    chk("R8 idle after enable sclk", sclk, 1);
    chk("R8 idle after enable txd", txd, 1);
    chk("R10 nothing pending", dataEmpty, 1);

    // R11: back-to-back async.
    syncMode = 1'b0;
    hostWrite(8'hC3);
    tick();
    chk("R11 first start", txd, 0);
    hostWrite(8'h1E);
    chk("R11 second pending", dataEmpty, 0);
    asyncRest(8'hC3, 1'b0, "R11a");
    tick();
    chk("R11 no gap start bit", txd, 0);
    chk("R11 empty on reload", dataEmpty, 1);
    asyncRest(8'h1E, 1'b0, "R11b");
    tick();
    chk("R11 idle after pair", txd, 1);

    // Random frames.
    for (int n = 0; n < 24; n++) begin
      b = DATA_W'($urandom());
      p = 1'($urandom());
      syncMode = 1'($urandom());
      parityEn = p;
      if (!syncMode) begin
        errOverrun = 1'($urandom()); errFraming = 1'($urandom()); errParity = 1'($urandom());
      end
      hostWrite(b);
      chk("rnd R2 write", dataEmpty, 0);
      if (syncMode) syncFrame(b, "rnd");
      else asyncFrame(b, p, "rnd R7");
      errOverrun = 1'b0; errFraming = 1'b0; errParity = 1'b0;
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule